// File: doc/BRIEF.md
# Header-Driven SPI Transfer Engine

This block is the master-side sequencer of an SPI port that takes all of its work from one shared byte buffer. Software fills the buffer through a simple byte port: a two-byte, big-endian operation header at the bottom, then the outgoing data. A single command write then starts the transfer. The command names a timing profile and a target slave. The engine reads the header to learn the operation type, the byte count and whether to move two bits per clock. It then walks the buffer, shifting bytes out on the data lines and storing received bytes back into the buffer from offset 0. While the transfer runs it holds a busy flag and drives the selected chip select.

Serial clock timing is generated elsewhere. The engine moves one serial-clock half period for each cycle in which `sck_en` is high. The serial clock idles low. A data bit is launched after a falling edge (or at the byte load) and sampled on the rising edge. Each timing profile holds a fill byte and a 3-wire enable. In 3-wire mode, data line `io0` is the single bidirectional line.

Top module: `hdr_spi_engine`

## Requirements
- R1: The header is read at buffer offsets 0 (high byte) and 1 (low byte). Header bits 9:0 are the byte count, bit 11 is the dual flag and bits 14:13 are the operation code: 1 = exchange, 2 = write-only, 3 = read-only. In byte 0 this places the code in bits 6:5, the dual flag in bit 3 and count bits 9:8 in bits 1:0.
- R2: A write-only operation shifts out, most significant bit first on `io0`, the bytes stored from offset 2 up.
- R3: A read-only operation stores the bytes sampled on `io1` at offsets 0 up. Meanwhile it shifts out the fill byte of the selected profile on `io0`.
- R4: An exchange operation sends the bytes from offset 2 up and, at the same time, stores the received bytes from offset 0 up.
- R5: When the dual flag is set on a write-only or read-only operation, two bits move per clock: `io1` carries the higher bit and `io0` the lower. On an exchange operation the flag is ignored.
- R6: With 3-wire enabled in the profile, `io0` is the only data line. It is released during read-only operations and is sampled there.
- R7: A write with `cmd_we` and `cmd_go` high starts an operation. It uses profile `cmd_prof` and drives `cs_n[cmd_slave]` low (all other bits high) for the whole operation.
- R8: `busy` is high from the cycle after an accepted start until the last byte completes, and is then low.
- R9: A byte count of 0, or operation code 0, leaves `busy` low and does not assert any chip select.
- R10: The byte count is limited to the buffer size minus 2 (510) for operations that transmit, and to the buffer size (512) for read-only operations.
- R11: A start written while `busy` is high is ignored. It changes neither the current transfer nor the slave selection, and it is not queued.
- R12: A buffer read issued while `busy` is high returns 0, and a buffer write issued then is dropped. When idle, a buffer read returns the stored byte one cycle later.
- R13: After reset `busy` is low, all chip selects are high and `sck` is low. Every profile holds fill byte 0xFF with 3-wire off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_en | input | 1 | One serial-clock half-period step per high cycle |
| buf_we | input | 1 | Buffer byte write strobe |
| buf_re | input | 1 | Buffer byte read strobe |
| buf_addr | input | 9 | Buffer byte address |
| buf_wdata | input | 8 | Buffer write data |
| buf_rdata | output | 8 | Buffer read data, valid the cycle after `buf_re` |
| cmd_we | input | 1 | Command write strobe |
| cmd_go | input | 1 | Start bit of the command |
| cmd_prof | input | 3 | Timing profile selected by the command |
| cmd_slave | input | 3 | Slave selected by the command |
| prof_we | input | 1 | Profile write strobe |
| prof_sel | input | 3 | Profile being written |
| prof_fill | input | 8 | Fill byte for the profile |
| prof_3w | input | 1 | 3-wire enable for the profile |
| busy | output | 1 | Transfer in progress |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 8 | Active-low chip selects |
| io0 | inout | 1 | Data out; dual low bit; 3-wire data line |
| io1 | inout | 1 | Data in; dual high bit |

## Verification
The hardest situation to reach is a transfer that hits the count limit. It needs a full buffer and hundreds of bytes on the wire. The bench writes a header with a count above the limit and fills every transmit slot. It then counts the bytes its slave model captures, for both a transmitting and a read-only operation. A second hard case is software touching the buffer or the command mid-transfer. Directed steps issue those accesses a few serial clocks into a running write. They then check the chip selects, the captured byte count and the buffer contents once `busy` falls.

// File: rtl/hse_pkg.sv
package hse_pkg;

  localparam int CNT_W  = 10;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_XCHG = 2'd1,
    OP_WR   = 2'd2,
    OP_RD   = 2'd3
  } op_e;

  typedef struct packed {
    op_e              op;
    logic             dual;
    logic [CNT_W-1:0] count;
  } hdr_t;

  // big-endian header: hi byte = bits 15:8, lo byte = bits 7:0
  function automatic hdr_t decode_hdr(input logic [7:0] b_hi, input logic [7:0] b_lo);
    hdr_t h;
    h.op    = op_e'(b_hi[6:5]);
    h.dual  = b_hi[3];
    h.count = {b_hi[1:0], b_lo};
    return h;
  endfunction

  // largest byte count one command may carry
  function automatic logic [CNT_W-1:0] count_limit(input op_e op, input int bufsz);
    return (op == OP_RD) ? CNT_W'(bufsz) : CNT_W'(bufsz - 2);
  endfunction

  function automatic logic [CNT_W-1:0] clamp_count(input hdr_t h, input int bufsz);
    logic [CNT_W-1:0] lim;
    lim = count_limit(h.op, bufsz);
    return (h.count > lim) ? lim : h.count;
  endfunction

  // two bits per clock only for one-direction operations
  function automatic logic dual_active(input hdr_t h);
    return h.dual && (h.op == OP_WR || h.op == OP_RD);
  endfunction

endpackage

// File: rtl/hse_buffer.sv
module hse_buffer #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic          h_we,
  input  logic          h_re,
  input  logic [AW-1:0] h_addr,
  input  logic [7:0]    h_wdata,
  output logic [7:0]    h_rdata,
  input  logic [AW-1:0] e_raddr,
  output logic [7:0]    e_rdata,
  output logic [7:0]    hdr_hi,
  output logic [7:0]    hdr_lo,
  input  logic          e_we,
  input  logic [AW-1:0] e_waddr,
  input  logic [7:0]    e_wdata
);

  logic [7:0] mem [DEPTH];

  wire host_wr_ok = h_we && !lock;

  always_ff @(posedge clk) begin
    if (host_wr_ok) mem[h_addr] <= h_wdata;
    if (e_we)       mem[e_waddr] <= e_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    h_rdata <= '0;
    else if (h_re) h_rdata <= lock ? 8'h00 : mem[h_addr];
  end

  assign e_rdata = mem[e_raddr];
  assign hdr_hi  = mem[0];
  assign hdr_lo  = mem[1];

  // R12: the engine writes only while the host side is locked out
  a_r12_engine_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
    e_we |-> lock);

endmodule

// File: rtl/hse_shifter.sv
module hse_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       dual,
  input  logic [1:0] rx_in,
  output logic       sck,
  output logic [1:0] tx_bits,
  output logic [7:0] rx_byte,
  output logic       done
);

  logic       active;
  logic [7:0] sh_tx;
  logic [3:0] nbits;

  wire rise_ev  = tick && active && !sck;
  wire fall_ev  = tick && active && sck;
  wire byte_end = fall_ev && (nbits == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sck     <= 1'b0;
      sh_tx   <= '0;
      rx_byte <= '0;
      nbits   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        active <= 1'b1;
        sck    <= 1'b0;
        sh_tx  <= load_byte;
        nbits  <= '0;
      end else if (rise_ev) begin
        sck     <= 1'b1;
        rx_byte <= dual ? {rx_byte[5:0], rx_in} : {rx_byte[6:0], rx_in[0]};
        nbits   <= nbits + (dual ? 4'd2 : 4'd1);
      end else if (byte_end) begin
        sck    <= 1'b0;
        active <= 1'b0;
        done   <= 1'b1;
      end else if (fall_ev) begin
        sck   <= 1'b0;
        sh_tx <= dual ? {sh_tx[5:0], 2'b00} : {sh_tx[6:0], 1'b0};
      end
    end
  end

  assign tx_bits = {sh_tx[7], dual ? sh_tx[6] : sh_tx[7]};

  // R2: never more than one byte of bits per load
  a_r2_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    nbits <= 4'd8);
  // R5: dual transfers advance in bit pairs
  a_r5_pair_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dual) |-> !nbits[0]);

endmodule

// File: rtl/hse_seq.sv
module hse_seq import hse_pkg::*; #(
  parameter int BUF_BYTES = 512,
  parameter int NUM_PROF  = 8,
  parameter int NUM_SLV   = 8,
  localparam int AW = $clog2(BUF_BYTES),
  localparam int PW = $clog2(NUM_PROF),
  localparam int SW = $clog2(NUM_SLV)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_we,
  input  logic               cmd_go,
  input  logic [PW-1:0]      cmd_prof,
  input  logic [SW-1:0]      cmd_slave,
  input  logic               prof_we,
  input  logic [PW-1:0]      prof_sel,
  input  logic [7:0]         prof_fill,
  input  logic               prof_3w,
  input  logic [7:0]         hdr_hi,
  input  logic [7:0]         hdr_lo,
  input  logic [7:0]         tx_mem_byte,
  input  logic               byte_done,
  output logic               busy,
  output logic [NUM_SLV-1:0] cs_n,
  output logic [AW-1:0]      tx_addr,
  output logic               load,
  output logic [7:0]         load_byte,
  output logic               rx_we,
  output logic [AW-1:0]      rx_addr,
  output op_e                op,
  output logic               dual,
  output logic               three_wire
);

  logic [7:0] fill_r [NUM_PROF];
  logic       w3_r   [NUM_PROF];

  for (genvar p = 0; p < NUM_PROF; p++) begin : g_prof
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fill_r[p] <= 8'hFF;
        w3_r[p]   <= 1'b0;
      end else if (prof_we && prof_sel == PW'(p)) begin
        fill_r[p] <= prof_fill;
        w3_r[p]   <= prof_3w;
      end
    end
  end

  hdr_t             hdr;
  logic [CNT_W-1:0] cnt_q, idx_q;
  logic [SW-1:0]    slave_q;
  logic [7:0]       fill_q;

  assign hdr = decode_hdr(hdr_hi, hdr_lo);

  wire accept    = cmd_we && cmd_go && !busy;
  wire launch    = accept && hdr.op != OP_NONE && hdr.count != '0;
  wire last_byte = byte_done && (idx_q == cnt_q - 1'b1);
  wire rx_op     = (op == OP_RD) || (op == OP_XCHG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      op         <= OP_NONE;
      dual       <= 1'b0;
      three_wire <= 1'b0;
      cnt_q      <= '0;
      idx_q      <= '0;
      slave_q    <= '0;
      fill_q     <= '0;
      load       <= 1'b0;
    end else begin
      load <= 1'b0;
      if (launch) begin
        busy       <= 1'b1;
        op         <= hdr.op;
        dual       <= dual_active(hdr);
        three_wire <= w3_r[cmd_prof];
        cnt_q      <= clamp_count(hdr, BUF_BYTES);
        idx_q      <= '0;
        slave_q    <= cmd_slave;
        fill_q     <= fill_r[cmd_prof];
        load       <= 1'b1;
      end else if (busy && byte_done) begin
        if (last_byte) begin
          busy <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
          load  <= 1'b1;
        end
      end
    end
  end

  assign tx_addr   = AW'(idx_q + CNT_W'(2));
  assign load_byte = (op == OP_RD) ? fill_q : tx_mem_byte;
  assign rx_we     = busy && byte_done && rx_op;
  assign rx_addr   = AW'(idx_q);

  for (genvar s = 0; s < NUM_SLV; s++) begin : g_cs
    assign cs_n[s] = !(busy && slave_q == SW'(s));
  end

  // R10: the byte index stays below the limited count
  a_r10_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q < cnt_q && cnt_q <= count_limit(op, BUF_BYTES)));
  // R11: a start during a transfer leaves the slave and count alone
  a_r11_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we) |=> (slave_q == $past(slave_q) && cnt_q == $past(cnt_q)));
  // R9: an empty header never raises busy
  a_r9_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hdr.count == '0) |=> !busy);

endmodule

// File: rtl/hdr_spi_engine.sv
module hdr_spi_engine import hse_pkg::*; #(
  parameter int BUF_BYTES = 512,
  parameter int NUM_PROF  = 8,
  parameter int NUM_SLV   = 8,
  localparam int AW = $clog2(BUF_BYTES),
  localparam int PW = $clog2(NUM_PROF),
  localparam int SW = $clog2(NUM_SLV)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_en,
  input  logic               buf_we,
  input  logic               buf_re,
  input  logic [AW-1:0]      buf_addr,
  input  logic [7:0]         buf_wdata,
  output logic [7:0]         buf_rdata,
  input  logic               cmd_we,
  input  logic               cmd_go,
  input  logic [PW-1:0]      cmd_prof,
  input  logic [SW-1:0]      cmd_slave,
  input  logic               prof_we,
  input  logic [PW-1:0]      prof_sel,
  input  logic [7:0]         prof_fill,
  input  logic               prof_3w,
  output logic               busy,
  output logic               sck,
  output logic [NUM_SLV-1:0] cs_n,
  inout  wire                io0,
  inout  wire                io1
);

  logic [AW-1:0] tx_addr, rx_addr;
  logic [7:0]    tx_mem_byte, hdr_hi, hdr_lo, load_byte, rx_byte;
  logic          load, rx_we, byte_done, dual, three_wire;
  logic [1:0]    tx_bits, rx_in;
  op_e           op;

  hse_buffer #(.DEPTH(BUF_BYTES)) buf_i (
    .clk(clk), .rst_n(rst_n), .lock(busy),
    .h_we(buf_we), .h_re(buf_re), .h_addr(buf_addr), .h_wdata(buf_wdata), .h_rdata(buf_rdata),
    .e_raddr(tx_addr), .e_rdata(tx_mem_byte), .hdr_hi(hdr_hi), .hdr_lo(hdr_lo),
    .e_we(rx_we), .e_waddr(rx_addr), .e_wdata(rx_byte)
  );

  hse_seq #(.BUF_BYTES(BUF_BYTES), .NUM_PROF(NUM_PROF), .NUM_SLV(NUM_SLV)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_we(cmd_we), .cmd_go(cmd_go), .cmd_prof(cmd_prof), .cmd_slave(cmd_slave),
    .prof_we(prof_we), .prof_sel(prof_sel), .prof_fill(prof_fill), .prof_3w(prof_3w),
    .hdr_hi(hdr_hi), .hdr_lo(hdr_lo), .tx_mem_byte(tx_mem_byte), .byte_done(byte_done),
    .busy(busy), .cs_n(cs_n), .tx_addr(tx_addr), .load(load), .load_byte(load_byte),
    .rx_we(rx_we), .rx_addr(rx_addr), .op(op), .dual(dual), .three_wire(three_wire)
  );

  hse_shifter shift_i (
    .clk(clk), .rst_n(rst_n), .tick(sck_en), .load(load), .load_byte(load_byte),
    .dual(dual), .rx_in(rx_in), .sck(sck), .tx_bits(tx_bits), .rx_byte(rx_byte),
    .done(byte_done)
  );

  // line direction: io0 released for reads on a shared or paired line
  wire rd_only = (op == OP_RD);
  wire oe0     = busy && !(rd_only && (dual || three_wire));
  wire oe1     = busy && dual && (op == OP_WR);

  assign io0 = oe0 ? tx_bits[0] : 1'bz;
  assign io1 = oe1 ? tx_bits[1] : 1'bz;

  assign rx_in = dual ? {io1, io0} : {1'b0, three_wire ? io0 : io1};

  // R7: exactly one chip select low while busy, none when idle
  a_r7_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(~cs_n) == 1));
  a_r7_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n));
  // R13: serial clock rests low outside a transfer
  a_r13_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // R8: busy only drops right after a completed byte
  a_r8_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(byte_done));
  // R12: host reads while busy come back as zero
  a_r12_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && buf_re) |=> (buf_rdata == 8'h00));

endmodule

// File: tb/hdr_spi_engine_tb_top.sv
module hdr_spi_engine_tb_top;

  typedef struct packed {
    logic [1:0] op;
    logic       dual;
    logic       w3;
    logic [9:0] cnt;
    logic [2:0] prof;
    logic [2:0] slv;
    logic [7:0] fill;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 1'b0, 1'b0, 10'd5, 3'd0, 3'd1, 8'hFF},
    '{2'd3, 1'b0, 1'b0, 10'd4, 3'd1, 3'd2, 8'hA5},
    '{2'd1, 1'b0, 1'b0, 10'd6, 3'd2, 3'd0, 8'h3C},
    '{2'd2, 1'b1, 1'b0, 10'd3, 3'd3, 3'd5, 8'h00},
    '{2'd3, 1'b1, 1'b0, 10'd4, 3'd4, 3'd3, 8'h00},
    '{2'd2, 1'b0, 1'b1, 10'd3, 3'd5, 3'd7, 8'h00},
    '{2'd3, 1'b0, 1'b1, 10'd4, 3'd6, 3'd6, 8'h5A},
    '{2'd1, 1'b1, 1'b0, 10'd3, 3'd7, 3'd4, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck_en = 1'b0;
  logic       buf_we = 1'b0, buf_re = 1'b0;
  logic [8:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0;
  logic [7:0] buf_rdata;
  logic       cmd_we = 1'b0, cmd_go = 1'b0;
  logic [2:0] cmd_prof = '0, cmd_slave = '0;
  logic       prof_we = 1'b0;
  logic [2:0] prof_sel = '0;
  logic [7:0] prof_fill = '0;
  logic       prof_3w = 1'b0;
  logic       busy, sck;
  logic [7:0] cs_n;
  wire        io0, io1;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  hdr_spi_engine dut_i (
    .clk(clk), .rst_n(rst_n), .sck_en(sck_en),
    .buf_we(buf_we), .buf_re(buf_re), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .cmd_we(cmd_we), .cmd_go(cmd_go), .cmd_prof(cmd_prof), .cmd_slave(cmd_slave),
    .prof_we(prof_we), .prof_sel(prof_sel), .prof_fill(prof_fill), .prof_3w(prof_3w),
    .busy(busy), .sck(sck), .cs_n(cs_n), .io0(io0), .io1(io1)
  );

  // ---------------- slave model ----------------
  int         cfg_op = 0;
  logic       cfg_dual = 1'b0, cfg_3w = 1'b0;
  logic [7:0] cap_mem [512];
  int         cap_cnt = 0;
  int         s_bits = 0;
  logic [7:0] s_sh = '0;

  function automatic logic [7:0] tx_b(input int i);
    return 8'((i * 13 + 100) ^ (i >> 4));
  endfunction
  function automatic logic [7:0] resp_b(input int i);
    return 8'((i * 29 + 5) ^ (i >> 3));
  endfunction

  wire        cs_act = ~&cs_n;
  logic [7:0] rs;
  always_comb rs = resp_b(cap_cnt) << s_bits;
  wire s_en1 = cs_act && !(cfg_dual && cfg_op == 2);
  wire s_en0 = cs_act && cfg_op == 3 && (cfg_dual || cfg_3w);
  assign io1 = s_en1 ? rs[7] : 1'bz;
  assign io0 = s_en0 ? (cfg_dual ? rs[6] : rs[7]) : 1'bz;

  always @(posedge sck) begin
    if (cs_act) begin
      if (cfg_dual) s_sh = {s_sh[5:0], io1, io0};
      else          s_sh = {s_sh[6:0], io0};
      s_bits = s_bits + (cfg_dual ? 2 : 1);
      if (s_bits == 8) begin
        cap_mem[cap_cnt % 512] = s_sh;
        cap_cnt = cap_cnt + 1;
        s_bits = 0;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    sck_en = ~sck_en;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input int a, input logic [7:0] d);
    buf_we = 1'b1; buf_addr = 9'(a); buf_wdata = d;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic hread(input int a, output logic [7:0] d);
    buf_re = 1'b1; buf_addr = 9'(a);
    @(negedge clk);
    buf_re = 1'b0;
    d = buf_rdata;
  endtask

  task automatic command(input logic [2:0] prof, input logic [2:0] slv);
    cmd_we = 1'b1; cmd_go = 1'b1; cmd_prof = prof; cmd_slave = slv;
    @(negedge clk);
    cmd_we = 1'b0; cmd_go = 1'b0;
  endtask

  task automatic setup(input logic [1:0] op, input logic dual, input logic w3, input logic [9:0] cnt,
                       input logic [2:0] prof, input logic [7:0] fill, input logic prog);
    if (prog) begin
      prof_we = 1'b1; prof_sel = prof; prof_fill = fill; prof_3w = w3;
      @(negedge clk);
      prof_we = 1'b0;
    end
    if (op != 2'd3)
      for (int i = 0; i < ((cnt > 10'd510) ? 510 : int'(cnt)); i++) hwrite(2 + i, tx_b(i));
    hwrite(0, {1'b0, op, 1'b0, dual, 1'b0, cnt[9:8]});
    hwrite(1, cnt[7:0]);
    cfg_op = int'(op);
    cfg_dual = dual && (op == 2'd2 || op == 2'd3);
    cfg_3w = w3;
    cap_cnt = 0;
    s_bits = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 40000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk("R13 busy after reset", 32'(busy), 32'd0);
    chk("R13 chip selects after reset", 32'(cs_n), 32'hFF);
    chk("R13 sck after reset", 32'(sck), 32'd0);

    // R13 default fill 0xFF on an unprogrammed profile
    setup(2'd3, 1'b0, 1'b0, 10'd2, 3'd0, 8'h00, 1'b0);
    command(3'd0, 3'd0);
    wait_idle();
    chk("R13 default fill count", 32'(cap_cnt), 32'd2);
    chk("R13 default fill byte", 32'(cap_mem[1]), 32'hFF);

    // table walk
    for (int v = 0; v < NV; v++) begin
      vec_t t = VEC[v];
      string tag;
      if (t.dual)           tag = "R5";
      else if (t.w3)        tag = "R6";
      else if (t.op == 2'd1) tag = "R4";
      else if (t.op == 2'd3) tag = "R3";
      else                  tag = "R2";
      setup(t.op, t.dual, t.w3, t.cnt, t.prof, t.fill, 1'b1);
      command(t.prof, t.slv);
      chk("R8 busy after start", 32'(busy), 32'd1);
      chk("R7 selected chip select", 32'(cs_n), 32'(8'(~(8'd1 << t.slv))));
      wait_idle();
      @(negedge clk);
      chk("R8 busy after last byte", 32'(busy), 32'd0);
      chk("R7 chip selects released", 32'(cs_n), 32'hFF);
      if (t.op != 2'd3 || (!t.dual && !t.w3))
        chk({"R1 byte count ", tag}, 32'(cap_cnt), 32'(t.cnt));
      if (t.op != 2'd3)
        for (int i = 0; i < int'(t.cnt); i++)
          chk({tag, " sent byte"}, 32'(cap_mem[i]), 32'(tx_b(i)));
      if (t.op == 2'd3 && !t.dual && !t.w3)
        for (int i = 0; i < int'(t.cnt); i++)
          chk("R3 fill on io0", 32'(cap_mem[i]), 32'(t.fill));
      if (t.op == 2'd3 || t.op == 2'd1)
        for (int i = 0; i < int'(t.cnt); i++) begin
          hread(i, d);
          chk({tag, " received byte"}, 32'(d), 32'(resp_b(i)));
        end
    end

    // R9 empty operations
    setup(2'd2, 1'b0, 1'b0, 10'd0, 3'd0, 8'h00, 1'b0);
    command(3'd0, 3'd2);
    @(negedge clk);
    chk("R9 zero count busy", 32'(busy), 32'd0);
    chk("R9 zero count chip select", 32'(cs_n), 32'hFF);
    setup(2'd0, 1'b0, 1'b0, 10'd3, 3'd0, 8'h00, 1'b0);
    command(3'd0, 3'd2);
    @(negedge clk);
    chk("R9 null opcode busy", 32'(busy), 32'd0);
    chk("R9 null opcode chip select", 32'(cs_n), 32'hFF);

    // R11 and R12 during a running write
    hwrite(300, 8'h11);
    setup(2'd2, 1'b0, 1'b0, 10'd4, 3'd0, 8'h00, 1'b0);
    command(3'd0, 3'd1);
    repeat (6) @(negedge clk);
    command(3'd0, 3'd6);
    chk("R11 chip select kept", 32'(cs_n), 32'hFD);
    hread(2, d);
    chk("R12 read while busy", 32'(d), 32'd0);
    hwrite(300, 8'h5A);
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R11 no queued start", 32'(busy), 32'd0);
    chk("R11 original byte count", 32'(cap_cnt), 32'd4);
    hread(300, d);
    chk("R12 write while busy dropped", 32'(d), 32'h11);
    hread(2, d);
    chk("R12 idle read", 32'(d), 32'(tx_b(0)));

    // R10 count limits
    setup(2'd2, 1'b0, 1'b0, 10'd700, 3'd0, 8'h00, 1'b0);
    command(3'd0, 3'd0);
    wait_idle();
    chk("R10 transmit limit", 32'(cap_cnt), 32'd510);
    chk("R10 last sent byte", 32'(cap_mem[509]), 32'(tx_b(509)));
    setup(2'd3, 1'b0, 1'b0, 10'd1023, 3'd1, 8'h00, 1'b0);
    command(3'd1, 3'd0);
    wait_idle();
    chk("R10 read limit", 32'(cap_cnt), 32'd512);
    hread(511, d);
    chk("R10 last received byte", 32'(d), 32'(resp_b(511)));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule